// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, for every frame, whether it may be handed to the client. As the first six bytes of a frame arrive (the destination address, in transmission order) each byte is compared at once against every recognized address. One registered pass/reject verdict comes out in the cycle after the sixth byte. The verdict stays until the next frame begins.

Recognized addresses come from three places. The first is a unicast register, loaded from a 48-bit tie-off input at reset and rewritable from the host. The second is a small table of up to four further addresses, reached indirectly through a staging word and a control word. The third is a fixed set: broadcast, the pause multicast address and a configured pause source address. A promiscuous mode, on out of reset, lets every frame pass. The host side is a simple register port with one write strobe and a read-data output that is purely combinational. Frame-check-sequence checking and frame buffering are handled elsewhere.

Top module: `eth_da_filter`

## Requirements
- R1: `match_valid` rises in the cycle after the sixth byte of a frame is accepted (a byte is accepted when `rx_valid` is high at a clock edge; `rx_sof` high marks the first byte). It falls in the cycle after the next `rx_sof` byte.
- R2: The first byte of a frame is compared with address bits 47:40 and the sixth byte with bits 7:0. A frame that differs from a stored address only in its sixth byte is rejected.
- R3: Host register 0 holds unicast bits 31:0 and register 1 holds unicast bits 47:32 in its bits 15:0. Both are loaded from `tie_ucast_addr` at reset and may be written by the host. A frame addressed to the unicast value passes.
- R4: Register 2 is the table staging word (address bits 31:0). A write to register 3 with bit 23 = 0 stores {bits 15:0 of that write, register 2} into the table entry chosen by bits 17:16. Frames addressed to that entry then pass.
- R5: A write to register 3 with bit 23 = 1 loads, by the next cycle, entry bits 31:0 into register 2 and entry bits 47:32 into register 3 bits 15:0. Register 3 keeps bits 17:16 and 23 as written.
- R6: Table entries reset to zero, and an all-zero entry never matches.
- R7: Broadcast FF-FF-FF-FF-FF-FF, pause multicast 01-80-C2-00-00-01 and the `pause_src_addr` input always pass.
- R8: With promiscuous mode off, a frame whose destination matches no recognized address gets `match_pass` = 0 when `match_valid` rises.
- R9: Register 4 bit 31 is promiscuous mode. It reads 1 after reset, and while it is set every frame of six or more bytes passes.
- R10: A frame that ends before its sixth byte never raises `match_valid` or `match_pass`.
- R11: Once made, the verdict holds through any further bytes of the same frame and through idle cycles, until the next `rx_sof` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tie_ucast_addr | input | 48 | Reset value of the unicast register |
| pause_src_addr | input | 48 | Configured pause source address, always recognized |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register select (0 to 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_data | input | 8 | Receive byte |
| match_valid | output | 1 | Verdict valid for the current frame |
| match_pass | output | 1 | Frame may pass to the client |

## Verification
The bench targets byte order: if the address bytes were taken in reverse, a frame that differs only in its last byte would wrongly pass. It aims at the zero-entry rule, where an empty table slot would otherwise let an all-zero destination through. It exercises the indirect table read, where a design that loaded the staging words late or not at all returns stale data. It sends a frame cut short before the sixth byte, which a design with a loose byte counter would judge anyway. It also keeps feeding bytes after the verdict, to catch a verdict that is recomputed or dropped before the next start of frame.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;
   localparam int MAC_W    = 48;
   localparam int BYTE_W   = 8;
   localparam int DA_BYTES = MAC_W / BYTE_W;
   localparam int POS_W    = 3;
   localparam int HOST_W   = 32;

   typedef enum logic [2:0] {
      REG_UC_LO  = 3'd0,
      REG_UC_HI  = 3'd1,
      REG_TB_LO  = 3'd2,
      REG_TB_CTL = 3'd3,
      REG_MODE   = 3'd4
   } daf_reg_e;

   localparam int CTL_DIR_BIT   = 23;
   localparam int PROMISC_BIT   = 31;

   localparam logic [MAC_W-1:0] ADDR_BCAST    = 48'hFFFF_FFFF_FFFF;
   localparam logic [MAC_W-1:0] ADDR_PAUSE_MC = 48'h0180_C200_0001;
   localparam int               FIXED_LANES   = 4;
endpackage

// File: rtl/daf_host_regs.sv
module daf_host_regs
   import eth_daf_pkg::*;
#(
   parameter int TABLE_DEPTH = 4,
   localparam int TBL_N = (TABLE_DEPTH > 0) ? TABLE_DEPTH : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MAC_W-1:0]  tie_ucast_addr,
   input  logic              host_we,
   input  logic [2:0]        host_addr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic [MAC_W-1:0]  ucast_addr,
   output logic [MAC_W-1:0]  tbl_entry [TBL_N],
   output logic              promisc
);
   logic [MAC_W-1:0] tbl_q [TBL_N];
   logic [31:0]      stg_lo_q;
   logic [15:0]      ctl_hi_q;
   logic [1:0]       ctl_loc_q;
   logic             ctl_dir_q;
   logic [MAC_W-1:0] ucast_q;
   logic             promisc_q;

   logic [1:0]       wr_loc;
   logic             loc_ok;
   logic             ctl_wr;
   logic [MAC_W-1:0] rd_entry;

   assign wr_loc = host_wdata[17:16];
   assign loc_ok = int'(wr_loc) < TABLE_DEPTH;
   assign ctl_wr = host_we && (host_addr == REG_TB_CTL);

   always_comb begin
      rd_entry = '0;
      for (int i = 0; i < TBL_N; i++) begin
         if (loc_ok && (int'(wr_loc) == i)) rd_entry = tbl_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ucast_q   <= tie_ucast_addr;
         promisc_q <= 1'b1;
         stg_lo_q  <= '0;
         ctl_hi_q  <= '0;
         ctl_loc_q <= '0;
         ctl_dir_q <= 1'b0;
      end else if (host_we) begin
         unique case (host_addr)
            REG_UC_LO:  ucast_q[31:0]  <= host_wdata;
            REG_UC_HI:  ucast_q[47:32] <= host_wdata[15:0];
            REG_TB_LO:  stg_lo_q       <= host_wdata;
            REG_TB_CTL: begin
               ctl_loc_q <= wr_loc;
               ctl_dir_q <= host_wdata[CTL_DIR_BIT];
               if (host_wdata[CTL_DIR_BIT]) begin
                  stg_lo_q <= rd_entry[31:0];
                  ctl_hi_q <= rd_entry[47:32];
               end else begin
                  ctl_hi_q <= host_wdata[15:0];
               end
            end
            REG_MODE:   promisc_q <= host_wdata[PROMISC_BIT];
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tbl_q[g] <= '0;
         end else if (ctl_wr && !host_wdata[CTL_DIR_BIT] && loc_ok
                      && (int'(wr_loc) == g)) begin
            tbl_q[g] <= {host_wdata[15:0], stg_lo_q};
         end
      end
      assign tbl_entry[g] = tbl_q[g];
   end

   always_comb begin
      unique case (host_addr)
         REG_UC_LO:  host_rdata = ucast_q[31:0];
         REG_UC_HI:  host_rdata = {16'h0, ucast_q[47:32]};
         REG_TB_LO:  host_rdata = stg_lo_q;
         REG_TB_CTL: host_rdata = {8'h0, ctl_dir_q, 5'h0, ctl_loc_q, ctl_hi_q};
         REG_MODE:   host_rdata = {promisc_q, 31'h0};
         default:    host_rdata = '0;
      endcase
   end

   assign ucast_addr = ucast_q;
   assign promisc    = promisc_q;

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_we && host_addr == REG_MODE) |=> $stable(promisc));
   // R9
   mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_addr == REG_MODE) |=> promisc == $past(host_wdata[PROMISC_BIT]));
endmodule

// File: rtl/daf_lane.sv
module daf_lane
   import eth_daf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              byte_live,
   input  logic [POS_W-1:0]  byte_pos,
   input  logic [MAC_W-1:0]  ref_addr,
   input  logic              lane_en,
   output logic              hit_now
);
   logic              ok_q;
   logic [MAC_W-1:0]  shifted;
   logic [BYTE_W-1:0] ref_byte;
   logic              eq;

   // first received byte lines up with bits 47:40
   assign shifted  = ref_addr >> (BYTE_W * (DA_BYTES - 1 - int'(byte_pos)));
   assign ref_byte = shifted[BYTE_W-1:0];
   assign eq       = (rx_data == ref_byte);
   assign hit_now  = lane_en && eq && (rx_sof || ok_q);

   always_ff @(posedge clk) begin
      if (!rst_n)                    ok_q <= 1'b0;
      else if (rx_valid && byte_live) ok_q <= hit_now;
   end
endmodule

// File: rtl/daf_decide.sv
module daf_decide
   import eth_daf_pkg::*;
#(
   parameter int NUM_LANES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_valid,
   input  logic                 rx_sof,
   input  logic                 promisc,
   input  logic [NUM_LANES-1:0] lane_hit,
   output logic                 byte_live,
   output logic [POS_W-1:0]     byte_pos,
   output logic                 match_valid,
   output logic                 match_pass
);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(DA_BYTES - 1);
   localparam logic [POS_W-1:0] DONE_CNT = POS_W'(DA_BYTES);

   logic [POS_W-1:0] cnt_q;
   logic             sixth;

   assign byte_pos  = rx_sof ? '0 : cnt_q;
   assign byte_live = rx_sof || ((cnt_q != '0) && (cnt_q < DONE_CNT));
   assign sixth     = rx_valid && byte_live && (byte_pos == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q       <= '0;
         match_valid <= 1'b0;
         match_pass  <= 1'b0;
      end else if (rx_valid) begin
         if (rx_sof) begin
            cnt_q       <= POS_W'(1);
            match_valid <= 1'b0;
            match_pass  <= 1'b0;
         end else if (byte_live) begin
            cnt_q <= cnt_q + POS_W'(1);
            if (sixth) begin
               match_valid <= 1'b1;
               match_pass  <= promisc || (|lane_hit);
            end
         end
      end
   end

   // R1
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_valid) |-> $past(rx_valid) && !$past(rx_sof) && $past(cnt_q) == LAST_POS);
   // R1
   sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_sof) |=> !match_valid && !match_pass);
   // R10
   pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match_pass |-> match_valid);
   // R9
   promisc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(match_valid) && $past(promisc)) |-> match_pass);
   // R11
   verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_sof) && match_valid |=> match_valid && $stable(match_pass));
   // R1
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= DONE_CNT);
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
   import eth_daf_pkg::*;
#(
   parameter int TABLE_DEPTH = 4,
   localparam int TBL_N     = (TABLE_DEPTH > 0) ? TABLE_DEPTH : 1,
   localparam int NUM_LANES = FIXED_LANES + TABLE_DEPTH
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [47:0] tie_ucast_addr,
   input  logic [47:0] pause_src_addr,
   input  logic        host_we,
   input  logic [2:0]  host_addr,
   input  logic [31:0] host_wdata,
   output logic [31:0] host_rdata,
   input  logic        rx_valid,
   input  logic        rx_sof,
   input  logic [7:0]  rx_data,
   output logic        match_valid,
   output logic        match_pass
);
   if (TABLE_DEPTH < 0 || TABLE_DEPTH > 4) begin : g_depth_bad
      $error("TABLE_DEPTH must lie in 0..4");
   end

   logic [MAC_W-1:0]     ucast_addr;
   logic [MAC_W-1:0]     tbl_entry [TBL_N];
   logic                 promisc;
   logic [MAC_W-1:0]     lane_ref [NUM_LANES];
   logic [NUM_LANES-1:0] lane_en;
   logic [NUM_LANES-1:0] lane_hit;
   logic                 byte_live;
   logic [POS_W-1:0]     byte_pos;

   daf_host_regs #(.TABLE_DEPTH(TABLE_DEPTH)) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .tie_ucast_addr (tie_ucast_addr),
      .host_we        (host_we),
      .host_addr      (host_addr),
      .host_wdata     (host_wdata),
      .host_rdata     (host_rdata),
      .ucast_addr     (ucast_addr),
      .tbl_entry      (tbl_entry),
      .promisc        (promisc)
   );

   assign lane_ref[0] = ucast_addr;
   assign lane_ref[1] = ADDR_BCAST;
   assign lane_ref[2] = ADDR_PAUSE_MC;
   assign lane_ref[3] = pause_src_addr;
   assign lane_en[FIXED_LANES-1:0] = '1;

   for (genvar t = 0; t < TABLE_DEPTH; t++) begin : g_tbl_lane
      assign lane_ref[FIXED_LANES+t] = tbl_entry[t];
      assign lane_en[FIXED_LANES+t]  = (tbl_entry[t] != '0);
   end

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      daf_lane u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .rx_valid  (rx_valid),
         .rx_sof    (rx_sof),
         .rx_data   (rx_data),
         .byte_live (byte_live),
         .byte_pos  (byte_pos),
         .ref_addr  (lane_ref[l]),
         .lane_en   (lane_en[l]),
         .hit_now   (lane_hit[l])
      );
   end

   daf_decide #(.NUM_LANES(NUM_LANES)) u_decide (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_valid    (rx_valid),
      .rx_sof      (rx_sof),
      .promisc     (promisc),
      .lane_hit    (lane_hit),
      .byte_live   (byte_live),
      .byte_pos    (byte_pos),
      .match_valid (match_valid),
      .match_pass  (match_pass)
   );
endmodule

// File: tb/eth_da_filter_bench.sv
module eth_da_filter_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] TIE_UC = 48'h02AA_BBCC_DDEE;
   localparam logic [47:0] PSA    = 48'h0A11_2233_4455;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        rx_valid = 1'b0;
   logic        rx_sof = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        match_valid;
   logic        match_pass;

   int checks = 0;
   int fails  = 0;
   bit exp_q[$];
   string tag_q[$];
   logic prev_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eth_da_filter u_eth_da_filter (
      .clk(clk), .rst_n(rst_n), .tie_ucast_addr(TIE_UC), .pause_src_addr(PSA),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
      .rx_data(rx_data), .match_valid(match_valid), .match_pass(match_pass)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops an expected verdict at each rising verdict
   always @(negedge clk) begin
      if (rst_n && match_valid && !prev_valid) begin
         if (exp_q.size() == 0) begin
            check("R1 unexpected verdict", 64'(match_valid), 64'(0));
         end else begin
            automatic bit e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, 64'(match_pass), 64'(e));
         end
      end
      prev_valid = match_valid;
   end

   task automatic host_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic send_frame(input logic [47:0] da, input int len, input bit exp, input string tag);
      if (len >= 6) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_sof   = (i == 0);
         rx_data  = (i < 6) ? da[47 - 8*i -: 8] : 8'(i);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset verdict low", 64'({match_valid, match_pass}), 64'(0));
      host_read(3'd4, rd);  check("R9 promisc default", 64'(rd), 64'(32'h8000_0000));
      host_read(3'd0, rd);  check("R3 unicast low reset", 64'(rd), 64'(TIE_UC[31:0]));
      host_read(3'd1, rd);  check("R3 unicast high reset", 64'(rd), 64'({16'h0, TIE_UC[47:32]}));

      send_frame(48'h1234_5678_9ABC, 8, 1'b1, "R9 promisc passes stranger");
      host_write(3'd4, 32'h0);
      send_frame(48'h1234_5678_9ABC, 8, 1'b0, "R8 stranger rejected");
      send_frame(TIE_UC, 6, 1'b1, "R3 unicast passes");
      send_frame({TIE_UC[47:8], 8'hEF}, 7, 1'b0, "R2 last byte differs");
      send_frame({8'h03, TIE_UC[39:0]}, 7, 1'b0, "R2 first byte differs");
      send_frame(48'hFFFF_FFFF_FFFF, 9, 1'b1, "R7 broadcast");
      send_frame(48'h0180_C200_0001, 9, 1'b1, "R7 pause multicast");
      send_frame(PSA, 9, 1'b1, "R7 pause source");
      send_frame(48'h0, 8, 1'b0, "R6 zero entry never matches");

      // table write of entry 2
      host_write(3'd2, 32'h3344_5566);
      host_write(3'd3, 32'h0002_1122);
      send_frame(48'h1122_3344_5566, 8, 1'b1, "R4 table entry passes");
      // clobber staging, then read entry 2 back
      host_write(3'd2, 32'hDEAD_BEEF);
      host_write(3'd3, 32'h0082_0000);
      host_read(3'd2, rd);  check("R5 read low word", 64'(rd), 64'(32'h3344_5566));
      host_read(3'd3, rd);  check("R5 read high word", 64'(rd), 64'(32'h0082_1122));
      host_read(3'd4, rd);  check("R9 promisc cleared", 64'(rd), 64'(0));

      // rewrite the unicast register
      host_write(3'd0, 32'h0BAD_F00D);
      host_write(3'd1, 32'h0000_0066);
      host_read(3'd1, rd);  check("R3 unicast high rewrite", 64'(rd), 64'(32'h66));
      send_frame(48'h0066_0BAD_F00D, 6, 1'b1, "R3 new unicast passes");
      send_frame(TIE_UC, 6, 1'b0, "R8 old unicast rejected");

      // short frame after a passing one
      send_frame(48'hFFFF_FFFF_FFFF, 6, 1'b1, "R7 broadcast again");
      send_frame(48'hFFFF_FFFF_FFFF, 4, 1'b0, "R10 short");
      check("R10 short frame no verdict", 64'({match_valid, match_pass}), 64'(0));

      // verdict hold over long frame and idle
      send_frame(PSA, 20, 1'b1, "R11 long frame");
      repeat (5) @(negedge clk);
      check("R11 verdict held", 64'({match_valid, match_pass}), 64'(2'b11));

      repeat (4) @(negedge clk);
      check("R1 all verdicts seen", 64'(exp_q.size()), 64'(0));
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule